// File: doc/BRIEF.md
# PWM-Reference Successive-Approximation ADC Controller

This block is the digital half of a slow, low-cost analog-to-digital converter. Three pieces sit outside it: an analog multiplexer that picks one of up to seven inputs, a comparator, and an RC filter. The filter turns a pulse-width-modulated output into a reference voltage. The controller sets the multiplexer select and then searches for the input level one bit at a time, from the most significant bit down to the least. For each bit it programs a trial duty code, waits for the filtered reference to settle, and reads the comparator.

The reference comes from a duty cycle, not from a parallel DAC. Every decision therefore waits a programmable number of PWM periods before the comparator is read. A host requests a conversion with a one-cycle start strobe and a channel number. It gets back a busy level and a one-cycle completion pulse, with the 8-bit code and the channel it belongs to. Channels cover battery current, battery voltage, battery temperature, battery type and three test points. Select code 7 is not a channel.

Top module: `sadc_ctrl`

## Requirements
- R1: Out of reset, busy_o, done_o and err_o are low, pwm_o is low and mux_sel_o is 0.
- R2: A start_i strobe while idle with sel_i other than 7 makes busy_o high on the next cycle. On that cycle mux_sel_o equals the requested channel.
- R3: A start_i strobe while idle with sel_i equal to 7 gives a one-cycle err_o pulse on the next cycle. busy_o stays low.
- R4: A start_i strobe while busy, with any sel_i, is ignored. mux_sel_o keeps its value, err_o stays low, and the result belongs to the original request.
- R5: pwm_o has a period of 2^RES_W (256) clocks. It is high for the first N clocks of each period, where N is the trial code. A new code takes effect only at a period boundary.
- R6: After a start, the select lines are held for one settling interval before any trial code is applied. For at least (SETTLE-1) full periods, pwm_o stays low.
- R7: The search is most-significant-bit first. The first trial code is 128. A trial bit is kept when the synchronized comparator input is 1 (input above reference) and cleared when it is 0. The comparator passes through a two-flop synchronizer.
- R8: Each of the RES_W+1 steps (channel settle plus one per bit) waits SETTLE period boundaries. A conversion keeps busy_o high for between (9*SETTLE-1)*256 and 9*SETTLE*256+4 clocks.
- R9: done_o is high for exactly one clock, on the cycle busy_o falls. On that cycle result_o holds the code and chan_o holds the channel. Both stay valid until the next completion.
- R10: Once a conversion is done, the trial code returns to 0. pwm_o is low from the next period boundary on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle conversion request |
| sel_i | input | SEL_W (3) | Requested channel, code 7 invalid |
| cmp_i | input | 1 | Asynchronous comparator output, 1 = input above reference |
| mux_sel_o | output | SEL_W (3) | Analog multiplexer select |
| pwm_o | output | 1 | PWM reference, filtered externally |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle pulse for a rejected select code |
| result_o | output | RES_W (8) | Conversion result |
| chan_o | output | SEL_W (3) | Channel of result_o |

## Verification
The assertions assume that start_i and sel_i are synchronous to clk. They also assume that sel_i is stable in the cycle start_i is high, and that SETTLE is at least 2. With those in place, the filtered level has a whole period at the new duty code before the synchronized comparator is read. The bench drives start and select just after a rising edge, and runs with SETTLE at 2. It models the filter as a running count of pwm_o high cycles over the last 256 clocks. It reports a 1 on the comparator when the selected channel's level is at least that count, which places the analog input half a step above its nominal code. The expected result of every conversion is therefore the nominal code itself.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_SELECT = 2'd1,
    S_TRIAL  = 2'd2
  } sadc_state_e;

  function automatic logic state_is_busy(input sadc_state_e st);
    return st != S_IDLE;
  endfunction

endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sadc_pwm.sv
module sadc_pwm #(
  parameter int RES_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RES_W-1:0] duty_i,
  output logic             pwm_o,
  output logic             tick_o,
  output logic [RES_W-1:0] duty_o
);
  localparam logic [RES_W-1:0] LAST_CNT = {RES_W{1'b1}};
  localparam logic [RES_W-1:0] TICK_CNT = LAST_CNT - 1'b1;

  logic [RES_W-1:0] cnt_q;
  logic [RES_W-1:0] duty_q;
  logic             wrap_w;

  function automatic logic pwm_level(input logic [RES_W-1:0] cnt,
                                     input logic [RES_W-1:0] duty);
    return cnt < duty;
  endfunction

  assign wrap_w = (cnt_q == LAST_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      duty_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (wrap_w) duty_q <= duty_i;
    end
  end

  assign pwm_o  = pwm_level(cnt_q, duty_q);
  assign tick_o = (cnt_q == TICK_CNT);
  assign duty_o = duty_q;
endmodule

// File: rtl/sadc_seq.sv
module sadc_seq
  import sadc_pkg::*;
#(
  parameter int RES_W   = 8,
  parameter int SEL_W   = 3,
  parameter int SETTLE  = 16,
  parameter int BAD_SEL = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             tick_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] code_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [RES_W-1:0] result_o,
  output logic [SEL_W-1:0] chan_o,
  output logic             decide_o
);
  localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;
  localparam int SET_W = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(RES_W - 1);
  localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE - 1);
  localparam logic [SEL_W-1:0] BAD_CODE = SEL_W'(BAD_SEL);

  sadc_state_e      state_q;
  logic [RES_W-1:0] code_q;
  logic [IDX_W-1:0] idx_q;
  logic [SET_W-1:0] settle_q;
  logic [SEL_W-1:0] sel_q;
  logic [RES_W-1:0] result_q;
  logic [SEL_W-1:0] chan_q;
  logic             done_q;
  logic             err_q;

  logic             step_done_w;
  logic             last_bit_w;
  logic [RES_W-1:0] code_kept_w;

  function automatic logic [RES_W-1:0] trial_bit(input logic [IDX_W-1:0] idx);
    logic [RES_W-1:0] m;
    m = '0;
    m[idx] = 1'b1;
    return m;
  endfunction

  function automatic logic [RES_W-1:0] keep_or_clear(input logic [RES_W-1:0] code,
                                                     input logic [IDX_W-1:0] idx,
                                                     input logic             above);
    return above ? code : (code & ~trial_bit(idx));
  endfunction

  assign step_done_w = tick_i && (settle_q == SET_LAST);
  assign last_bit_w  = (idx_q == '0);
  assign code_kept_w = keep_or_clear(code_q, idx_q, cmp_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      code_q   <= '0;
      idx_q    <= '0;
      settle_q <= '0;
      sel_q    <= '0;
      result_q <= '0;
      chan_q   <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (start_i) begin
            if (sel_i == BAD_CODE) begin
              err_q <= 1'b1;
            end else begin
              sel_q    <= sel_i;
              settle_q <= '0;
              state_q  <= S_SELECT;
            end
          end
        end
        S_SELECT: begin
          if (tick_i) begin
            if (step_done_w) begin
              settle_q <= '0;
              code_q   <= trial_bit(TOP_IDX);
              idx_q    <= TOP_IDX;
              state_q  <= S_TRIAL;
            end else begin
              settle_q <= settle_q + 1'b1;
            end
          end
        end
        S_TRIAL: begin
          if (tick_i) begin
            if (step_done_w) begin
              settle_q <= '0;
              if (last_bit_w) begin
                result_q <= code_kept_w;
                chan_q   <= sel_q;
                done_q   <= 1'b1;
                code_q   <= '0;
                state_q  <= S_IDLE;
              end else begin
                code_q <= code_kept_w | trial_bit(idx_q - 1'b1);
                idx_q  <= idx_q - 1'b1;
              end
            end else begin
              settle_q <= settle_q + 1'b1;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign code_o   = code_q;
  assign sel_o    = sel_q;
  assign busy_o   = state_is_busy(state_q);
  assign done_o   = done_q;
  assign err_o    = err_q;
  assign result_o = result_q;
  assign chan_o   = chan_q;
  assign decide_o = (state_q == S_TRIAL) && step_done_w;
endmodule

// File: rtl/sadc_ctrl.sv
module sadc_ctrl #(
  parameter int RES_W       = 8,
  parameter int SEL_W       = 3,
  parameter int SETTLE      = 16,
  parameter int BAD_SEL     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             cmp_i,
  output logic [SEL_W-1:0] mux_sel_o,
  output logic             pwm_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [RES_W-1:0] result_o,
  output logic [SEL_W-1:0] chan_o
);
  logic             cmp_sync_w;
  logic             tick_w;
  logic             decide_w;
  logic [RES_W-1:0] code_w;
  logic [RES_W-1:0] duty_w;

  sadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cmp_i),
    .q_o   (cmp_sync_w)
  );

  sadc_pwm #(.RES_W(RES_W)) u_pwm (
    .clk    (clk),
    .rst_n  (rst_n),
    .duty_i (code_w),
    .pwm_o  (pwm_o),
    .tick_o (tick_w),
    .duty_o (duty_w)
  );

  sadc_seq #(
    .RES_W   (RES_W),
    .SEL_W   (SEL_W),
    .SETTLE  (SETTLE),
    .BAD_SEL (BAD_SEL)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .sel_i    (sel_i),
    .tick_i   (tick_w),
    .cmp_i    (cmp_sync_w),
    .code_o   (code_w),
    .sel_o    (mux_sel_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .err_o    (err_o),
    .result_o (result_o),
    .chan_o   (chan_o),
    .decide_o (decide_w)
  );
endmodule

// File: rtl/sadc_ctrl_chk.sv
module sadc_ctrl_chk #(
  parameter int RES_W   = 8,
  parameter int SEL_W   = 3,
  parameter int BAD_SEL = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [SEL_W-1:0] sel_i,
  input logic [SEL_W-1:0] mux_sel_o,
  input logic             pwm_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o,
  input logic [SEL_W-1:0] chan_o,
  input logic             tick_w,
  input logic             decide_w,
  input logic [RES_W-1:0] code_w,
  input logic [RES_W-1:0] duty_w
);
  localparam logic [SEL_W-1:0] BAD_CODE = SEL_W'(BAD_SEL);

  AST_BAD_SEL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && sel_i == BAD_CODE) |=> (err_o && !busy_o)); // R3

  AST_GOOD_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && sel_i != BAD_CODE) |=> (busy_o && mux_sel_o == $past(sel_i))); // R2

  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(mux_sel_o)); // R4

  AST_NO_ERR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> !err_o); // R4

  AST_DECIDE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    decide_w |-> (tick_w && busy_o)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && chan_o == mux_sel_o)); // R9

  AST_IDLE_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (code_w == '0)); // R10

  AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_w == '0) |-> !pwm_o); // R5
endmodule

bind sadc_ctrl sadc_ctrl_chk #(
  .RES_W   (RES_W),
  .SEL_W   (SEL_W),
  .BAD_SEL (BAD_SEL)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .sel_i     (sel_i),
  .mux_sel_o (mux_sel_o),
  .pwm_o     (pwm_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .chan_o    (chan_o),
  .tick_w    (tick_w),
  .decide_w  (decide_w),
  .code_w    (code_w),
  .duty_w    (duty_w)
);

// File: tb/sadc_ctrl_tb.sv
`timescale 1ns/1ps
module sadc_ctrl_tb_top;
  localparam int RES_W  = 8;
  localparam int SEL_W  = 3;
  localparam int SETTLE = 2;
  localparam int PER    = 256;
  localparam int LIMIT  = 190000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [SEL_W-1:0] sel_i = '0;
  logic             cmp_i;
  logic [SEL_W-1:0] mux_sel_o;
  logic             pwm_o;
  logic             busy_o;
  logic             done_o;
  logic             err_o;
  logic [RES_W-1:0] result_o;
  logic [SEL_W-1:0] chan_o;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  // analog model: level per channel, RC filter as 256-clock running average
  logic [7:0]   vin [0:7];
  logic [255:0] hist;
  int           win_cnt;

  always #2.5 clk = ~clk;

  sadc_ctrl #(.RES_W(RES_W), .SEL_W(SEL_W), .SETTLE(SETTLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sel_i(sel_i), .cmp_i(cmp_i),
    .mux_sel_o(mux_sel_o), .pwm_o(pwm_o), .busy_o(busy_o), .done_o(done_o),
    .err_o(err_o), .result_o(result_o), .chan_o(chan_o)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      hist    <= '0;
      win_cnt <= 0;
    end else begin
      hist    <= {hist[254:0], pwm_o};
      win_cnt <= win_cnt + int'(pwm_o) - int'(hist[255]);
    end
  end
  assign cmp_i = (int'(vin[mux_sel_o]) >= win_cnt);

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > LIMIT) begin
      errors = errors + 1;
      $display("FAIL watchdog (all requirements) actual=%0d expected<%0d", cyc, LIMIT);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick1();
    @(posedge clk); #1;
  endtask

  task automatic pulse_start(input int ch);
    tick1();
    start_i = 1'b1; sel_i = SEL_W'(ch);
    tick1();
    start_i = 1'b0;
  endtask

  task automatic t_reset();
    chk(busy_o == 1'b0, "R1 busy after reset", busy_o, 0);
    chk(done_o == 1'b0 && err_o == 1'b0, "R1 done/err after reset", {done_o, err_o}, 0);
    chk(mux_sel_o == '0, "R1 mux_sel after reset", mux_sel_o, 0);
    begin
      int highs = 0;
      for (int i = 0; i < 2 * PER; i++) begin tick1(); highs += int'(pwm_o); end
      chk(highs == 0, "R1 pwm low out of reset", highs, 0);
    end
  endtask

  task automatic t_bad_sel();
    pulse_start(7);
    chk(err_o == 1'b1, "R3 err pulse", err_o, 1);
    chk(busy_o == 1'b0, "R3 no busy on bad select", busy_o, 0);
    tick1();
    chk(err_o == 1'b0, "R3 err one cycle", err_o, 0);
    chk(busy_o == 1'b0, "R3 still idle", busy_o, 0);
  endtask

  task automatic wait_idle_low();
    int highs = 0;
    repeat (4) tick1();
    for (int i = 0; i < 2 * PER; i++) begin tick1(); highs += int'(pwm_o); end
    chk(highs == 0, "R10 pwm low after done", highs, 0);
  endtask

  task automatic run_conv(input int ch, input int v);
    int busy_cyc = 1;
    int highs = 0;
    vin[ch] = v[7:0];
    pulse_start(ch);
    chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
    chk(int'(mux_sel_o) == ch, "R2 mux_sel follows request", mux_sel_o, ch);
    for (int i = 0; i < (SETTLE - 1) * PER; i++) begin
      tick1(); highs += int'(pwm_o); if (busy_o) busy_cyc++;
    end
    chk(highs == 0, "R6 no trial during channel settle", highs, 0);
    while (!done_o) begin tick1(); if (busy_o) busy_cyc++; end
    chk(busy_o == 1'b0, "R9 busy falls with done", busy_o, 0);
    chk(int'(result_o) == v, "R7 result code", result_o, v);
    chk(int'(chan_o) == ch, "R9 channel tag", chan_o, ch);
    chk(busy_cyc >= (9 * SETTLE - 1) * PER && busy_cyc <= 9 * SETTLE * PER + 4,
        "R8 conversion length", busy_cyc, 9 * SETTLE * PER);
    tick1();
    chk(done_o == 1'b0, "R9 done one cycle", done_o, 0);
    chk(int'(result_o) == v, "R9 result held", result_o, v);
    wait_idle_low();
  endtask

  task automatic t_pwm_shape();
    int hi = 0;
    int per = 0;
    vin[0] = 8'd255;
    pulse_start(0);
    while (!pwm_o) tick1();
    while (pwm_o) begin tick1(); hi++; per++; end
    chk(hi == 128, "R5 R7 first trial high time", hi, 128);
    while (!pwm_o) begin tick1(); per++; end
    chk(per == PER, "R5 period", per, PER);
    while (!done_o) tick1();
    chk(result_o == 8'd255, "R7 full scale", result_o, 255);
    wait_idle_low();
  endtask

  task automatic t_busy_ignore();
    vin[1] = 8'd100;
    vin[2] = 8'd7;
    pulse_start(1);
    repeat (300) tick1();
    pulse_start(2);
    chk(mux_sel_o == 3'd1, "R4 select unchanged by start while busy", mux_sel_o, 1);
    pulse_start(7);
    chk(err_o == 1'b0, "R4 no err while busy", err_o, 0);
    while (!done_o) tick1();
    chk(result_o == 8'd100, "R4 result of original request", result_o, 100);
    chk(chan_o == 3'd1, "R4 channel of original request", chan_o, 1);
    wait_idle_low();
  endtask

  initial begin
    for (int i = 0; i < 8; i++) vin[i] = 8'd0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    tick1();
    t_reset();
    t_bad_sel();
    run_conv(0, 0);
    run_conv(3, 255);
    run_conv(1, 8'h5A);
    run_conv(6, 1);
    run_conv(5, 128);
    run_conv(2, 127);
    t_pwm_shape();
    t_busy_ignore();
    summary();
    $finish;
  end
endmodule